// File: doc/BRIEF.md
# Clock Generator Configuration Register File with Block-Access Serial Slave

This block holds the configuration bytes of a system clock generator and lets a host change and inspect them over a two-wire serial bus (SMBus/I2C, standard-mode rates or slower). The stored bytes leave the block as one flat vector. Other logic on the chip uses them for frequency selection, spread enable, per-output enables, watchdog settings and divider ratios. SCL and SDA pass through synchronizers into the system clock domain. The open-drain SDA pad is split into a sampled `sda_in` and a pull-low enable `sda_oe`.

The bus access has no register addressing. A write names the device, then sends a command byte and a byte count, and the block takes both and discards them. After that, data bytes fill the registers from byte 0 upward until STOP. A read returns a byte count first and then bytes from index 0 upward. The length of a read comes from a stored register, not from the host. Two register pairs are loaded through shadow copies, so a divider or spread setting never appears half-written.

Top module: `smbcfg_regfile`

## Requirements
- R1: After synchronous reset, bytes 1 to 5 hold 0xFF, byte 7 holds 0x90, byte 8 holds 0x08, byte 9 holds 0x10, and every other byte holds 0x00.
- R2: The device address byte 0xD2 (write) or 0xD3 (read) is acknowledged. Any other address byte is not acknowledged, and the transaction after it changes nothing.
- R3: In a write, the two bytes after the address (command and count) are acknowledged and their values are discarded.
- R4: In a write, data bytes are acknowledged and stored at indices 0, 1, 2 and so on in arrival order. A STOP after any complete byte leaves all later indices unchanged. Register updates happen only while SCL is low or right after a STOP.
- R5: A read first returns the value of byte 8 as the byte count, then returns that many bytes starting at index 0, each MSB first.
- R6: A read of an index at or beyond 21 returns 0x00.
- R7: Byte 7 is read-only. Its value 0x90 (upper nibble 1001) survives any write.
- R8: Bytes 11 and 12 form one pair, and bytes 13 and 14 form another. A pair's live values change only at STOP, and only when both bytes of that pair arrived in the same transaction.
- R9: A NACK from the master ends a read, and so does an ACK of the last counted byte. The slave then leaves SDA released until the next START, and it never drives SDA while idle.
- R10: The slave begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the SDA pad low, 0 releases it |
| cfg_o | output | NUM_BYTES*8 | Live register bytes; byte i sits at bits [8i+7:8i] |

## Verification
The bound checker watches, on every cycle, the timing-shaped rules. It checks that the live bytes show the reset defaults and change only while SCL is low or just after a STOP, that both register pairs move only at STOP, that SDA is released whenever the bus machine is idle, and that the slave starts driving only with SCL low. Other rules depend on the content of whole transactions, and only the bench's scenarios can show them. These are that command and count bytes are discarded, that a write cut short leaves later bytes alone, that a pair with one half missing is not committed, that the read length follows byte 8 and pads past the end with zeros, and that an address for another device gets no acknowledge.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WR,
        ST_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_RD_NEXT
    } bus_state_t;

    // Decoded line events in the system clock domain
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl;
        logic sda;
    } line_ev_t;

    // One-cycle store request from the bus machine to the register file
    typedef struct packed {
        logic       en;
        logic [7:0] idx;
        logic [7:0] data;
    } wr_req_t;

    localparam int         VENDOR_IDX = 7;
    localparam logic [7:0] VENDOR_VAL = 8'h90;
    localparam int         COUNT_IDX  = 8;
    localparam int         PAIR_FIRST = 11;
    localparam int         PAIR_SLOTS = 4;
    localparam logic [7:0] HDR_BYTES  = 8'd2;

    function automatic logic [7:0] default_byte(input int idx);
        case (idx)
            1, 2, 3, 4, 5: default_byte = 8'hFF;
            VENDOR_IDX:    default_byte = VENDOR_VAL;
            COUNT_IDX:     default_byte = 8'h08;
            9:             default_byte = 8'h10;
            default:       default_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smbcfg_line_sync.sv
module smbcfg_line_sync
    import smbcfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    // stage [0] metastability, [1] current, [2] previous
    logic [2:0] scl_q;
    logic [2:0] sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[1:0], scl_in};
            sda_q <= {sda_q[1:0], sda_in};
        end
    end

    always_comb begin
        ev.scl      = scl_q[1];
        ev.sda      = sda_q[1];
        ev.scl_rise = scl_q[1] & ~scl_q[2];
        ev.scl_fall = ~scl_q[1] & scl_q[2];
        ev.start    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
        ev.stop     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
    end

endmodule

// File: rtl/smbcfg_regs.sv
module smbcfg_regs
    import smbcfg_pkg::*;
#(
    parameter int NUM_BYTES = 21
) (
    input  logic                   clk,
    input  logic                   rst,
    input  wr_req_t                wr,
    input  logic                   txn_start,
    input  logic                   commit,
    input  logic [7:0]             rd_idx,
    output logic [7:0]             rd_data,
    output logic [NUM_BYTES*8-1:0] cfg
);
    logic [7:0]            shadow [PAIR_SLOTS];
    logic [PAIR_SLOTS-1:0] got;
    logic [7:0]            off;
    logic                  in_pair;
    logic [1:0]            slot;
    logic                  commit_a;
    logic                  commit_b;

    assign off      = wr.idx - 8'(PAIR_FIRST);
    assign in_pair  = off < 8'(PAIR_SLOTS);
    assign slot     = off[1:0];
    assign commit_a = commit & got[0] & got[1];
    assign commit_b = commit & got[2] & got[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            got <= '0;
            for (int i = 0; i < PAIR_SLOTS; i++) shadow[i] <= '0;
        end else begin
            if (wr.en && in_pair) shadow[slot] <= wr.data;
            if (txn_start || commit) got <= '0;
            else if (wr.en && in_pair) got[slot] <= 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_BYTES; g++) begin : gen_byte
        logic [7:0] q;
        if (g == VENDOR_IDX) begin : g_ro
            assign q = VENDOR_VAL;
        end else if (g >= PAIR_FIRST && g < PAIR_FIRST + PAIR_SLOTS) begin : g_pair
            localparam int S = g - PAIR_FIRST;
            always_ff @(posedge clk) begin
                if (rst) q <= default_byte(g);
                else if ((S < 2) ? commit_a : commit_b) q <= shadow[S];
            end
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (rst) q <= default_byte(g);
                else if (wr.en && wr.idx == 8'(g)) q <= wr.data;
            end
        end
        assign cfg[g*8 +: 8] = q;
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_BYTES; i++)
            if (rd_idx == 8'(i)) rd_data = cfg[i*8 +: 8];
    end

endmodule

// File: rtl/smbcfg_slave_fsm.sv
module smbcfg_slave_fsm
    import smbcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   ev,
    input  logic [7:0] count_val,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_idx,
    output wr_req_t    wr,
    output logic       sda_oe,
    output logic       busy
);
    bus_state_t state;
    logic [7:0] shreg, tx, wcnt, sent, ptr;
    logic [3:0] bitcnt;
    logic       is_read;
    logic       oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            tx      <= '0;
            wcnt    <= '0;
            sent    <= '0;
            ptr     <= '0;
            bitcnt  <= '0;
            is_read <= 1'b0;
            oe      <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                oe     <= 1'b0;
                wcnt   <= '0;
            end else if (ev.stop) begin
                state <= ST_IDLE;
                oe    <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (ev.scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    is_read <= shreg[0];
                                    oe      <= 1'b1;
                                    state   <= ST_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                oe    <= 1'b1;
                                state <= ST_ACK;
                                if (wcnt != 8'hFF) wcnt <= wcnt + 8'd1;
                                if (wcnt >= HDR_BYTES) begin
                                    wr.en   <= 1'b1;
                                    wr.idx  <= wcnt - HDR_BYTES;
                                    wr.data <= shreg;
                                end
                            end
                        end
                    end
                    ST_ACK: if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (is_read) begin
                            tx    <= count_val;
                            oe    <= ~count_val[7];
                            sent  <= '0;
                            ptr   <= '0;
                            state <= ST_RD;
                        end else begin
                            oe    <= 1'b0;
                            state <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (ev.scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                oe     <= 1'b0;
                                bitcnt <= '0;
                                state  <= ST_RD_ACK;
                            end else begin
                                tx <= {tx[6:0], 1'b0};
                                oe <= ~tx[6];
                            end
                        end
                    end
                    ST_RD_ACK: if (ev.scl_rise) begin
                        state <= (!ev.sda && sent < count_val) ? ST_RD_NEXT : ST_IDLE;
                    end
                    ST_RD_NEXT: if (ev.scl_fall) begin
                        tx    <= rd_data;
                        oe    <= ~rd_data[7];
                        ptr   <= ptr + 8'd1;
                        sent  <= sent + 8'd1;
                        state <= ST_RD;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe = oe;
    assign rd_idx = ptr;
    assign busy   = (state != ST_IDLE);

endmodule

// File: rtl/smbcfg_regfile.sv
module smbcfg_regfile
    import smbcfg_pkg::*;
#(
    parameter int         NUM_BYTES = 21,
    parameter logic [6:0] DEV_ADDR  = 7'h69
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_oe,
    output logic [NUM_BYTES*8-1:0] cfg_o
);
    line_ev_t   ev;
    wr_req_t    wr;
    logic [7:0] rd_idx;
    logic [7:0] rd_data;
    logic [7:0] count_val;
    logic       busy;
    logic       scl_s;
    logic       stop_ev;

    assign count_val = cfg_o[COUNT_IDX*8 +: 8];
    assign scl_s     = ev.scl;
    assign stop_ev   = ev.stop;

    smbcfg_line_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    smbcfg_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .count_val (count_val),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr        (wr),
        .sda_oe    (sda_oe),
        .busy      (busy)
    );

    smbcfg_regs #(.NUM_BYTES(NUM_BYTES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .txn_start (ev.start),
        .commit    (ev.stop),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .cfg       (cfg_o)
    );

endmodule

// File: rtl/smbcfg_checker.sv
module smbcfg_checker
    import smbcfg_pkg::*;
#(
    parameter int NUM_BYTES = 21
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   scl_s,
    input logic                   stop_ev,
    input logic                   busy,
    input logic                   sda_oe,
    input logic [NUM_BYTES*8-1:0] cfg_o
);
    logic                   rst_q;
    logic [NUM_BYTES*8-1:0] dflt;
    logic [31:0]            pair_v;

    always_ff @(posedge clk) rst_q <= rst;

    always_comb begin
        for (int i = 0; i < NUM_BYTES; i++) dflt[i*8 +: 8] = default_byte(i);
    end

    assign pair_v = cfg_o[PAIR_FIRST*8 +: 32];

    a_r1_reset_defaults: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> cfg_o == dflt)
        else $error("a_r1_reset_defaults");

    a_r4_update_scl_low: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && $changed(cfg_o)) |-> (!scl_s || $past(stop_ev)))
        else $error("a_r4_update_scl_low");

    a_r8_pair_at_stop: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && $changed(pair_v)) |-> $past(stop_ev))
        else $error("a_r8_pair_at_stop");

    a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sda_oe)
        else $error("a_r9_idle_released");

    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && $rose(sda_oe)) |-> !scl_s)
        else $error("a_r10_drive_scl_low");

endmodule

bind smbcfg_regfile smbcfg_checker #(.NUM_BYTES(NUM_BYTES)) u_checker (
    .clk     (clk),
    .rst     (rst),
    .scl_s   (scl_s),
    .stop_ev (stop_ev),
    .busy    (busy),
    .sda_oe  (sda_oe),
    .cfg_o   (cfg_o)
);

// File: tb/smbcfg_regfile_bench.sv
`timescale 1ns/1ps
module smbcfg_regfile_bench;
    localparam int NB = 21;
    localparam int Q  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NB*8-1:0] cfg;

    assign sda_line = sda_m & ~sda_oe;
    always #2 clk = ~clk;

    smbcfg_regfile u_smbcfg_regfile (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl),
        .sda_in (sda_line),
        .sda_oe (sda_oe),
        .cfg_o  (cfg)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int mism    = 0;
    int cmp_n   = 0;
    bit hold    = 1'b1;
    bit done    = 1'b0;

    // behavioural model of the register contents
    logic [7:0] exp_b [NB];
    logic [7:0] sh [4];
    bit         got [4];
    logic [7:0] wbuf [32];
    logic [7:0] rbuf [32];
    logic [7:0] rcount;
    bit ack_addr, ack_hdr, ack_data, drove;

    function automatic logic [7:0] dflt(int i);
        if (i >= 1 && i <= 5) return 8'hFF;
        if (i == 7) return 8'h90;
        if (i == 8) return 8'h08;
        if (i == 9) return 8'h10;
        return 8'h00;
    endfunction

    function automatic logic [NB*8-1:0] model_flat();
        logic [NB*8-1:0] v;
        for (int i = 0; i < NB; i++) v[i*8 +: 8] = exp_b[i];
        return v;
    endfunction

    function automatic logic [7:0] cb(int i);
        return cfg[i*8 +: 8];
    endfunction

    function automatic logic [7:0] exp_rd(int i);
        if (i >= NB) return 8'h00;
        return exp_b[i];
    endfunction

    // model applies a data byte at position k of a write
    task automatic model_store(int k, logic [7:0] v);
        if (k >= 11 && k <= 14) begin
            sh[k-11]  = v;
            got[k-11] = 1'b1;
        end else if (k < NB && k != 7) begin
            exp_b[k] = v;
        end
    endtask

    task automatic model_commit();
        if (got[0] && got[1]) begin exp_b[11] = sh[0]; exp_b[12] = sh[1]; end
        if (got[2] && got[3]) begin exp_b[13] = sh[2]; exp_b[14] = sh[3]; end
        for (int i = 0; i < 4; i++) got[i] = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && !hold) begin
            cmp_n++;
            if (cfg !== model_flat()) mism++;
        end
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic wq(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl = 1'b1; wq(2*Q);
            scl = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        acked = !sda_line;
        wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl = 1'b1; wq(Q);
            b[i] = sda_line;
            wq(Q);
            scl = 1'b0; wq(Q);
        end
        sda_m = ack ? 1'b0 : 1'b1; wq(Q);
        scl = 1'b1; wq(2*Q);
        scl = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic watch(int n, output bit d);
        d = 1'b0;
        sda_m = 1'b1;
        for (int i = 0; i < n; i++) begin
            wq(Q); if (sda_oe) d = 1'b1;
            scl = 1'b1; wq(Q); if (sda_oe) d = 1'b1;
            wq(Q);
            scl = 1'b0; wq(Q); if (sda_oe) d = 1'b1;
        end
    endtask

    task automatic write_txn(int n);
        bit a;
        hold = 1'b1;
        ack_hdr = 1'b1; ack_data = 1'b1;
        i2c_start();
        send_byte(8'hD2, ack_addr);
        send_byte(8'h5A, a); ack_hdr &= a;
        send_byte(8'(n), a); ack_hdr &= a;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a); ack_data &= a;
            model_store(k, wbuf[k]);
        end
        i2c_stop();
        model_commit();
        wq(4);
        hold = 1'b0;
    endtask

    task automatic read_txn(int n, bit nack_end, int watch_n);
        i2c_start();
        send_byte(8'hD3, ack_addr);
        recv_byte(1'b1, rcount);
        for (int k = 0; k < n; k++)
            recv_byte(!(nack_end && k == n-1), rbuf[k]);
        drove = 1'b0;
        if (watch_n > 0) watch(watch_n, drove);
        i2c_stop();
    endtask

    task automatic summary();
        if (mism != 0)
            $display("FAIL R4 live bytes differ from model on %0d of %0d clocks: actual=%0d expected=0", mism, cmp_n, mism);
        n_tests++;
        if (mism != 0) n_fail++;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) exp_b[i] = dflt(i);
        for (int i = 0; i < 4; i++) begin sh[i] = 8'h00; got[i] = 1'b0; end
        for (int i = 0; i < 32; i++) wbuf[i] = 8'(8'h31 + i*13);
        wbuf[7] = 8'h00;
        wbuf[8] = 8'h08;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        wq(4);
        hold = 1'b0;

        // R1 reset values
        check(cfg == model_flat(), "R1 reset contents", cfg[31:0], model_flat() >> 0);
        check(cb(8) == 8'h08 && cb(7) == 8'h90 && cb(9) == 8'h10 && cb(3) == 8'hFF,
              "R1 default bytes", {cb(3), cb(7), cb(8), cb(9)}, 32'hFF900810);

        // R5 default read: count then bytes 0..7; R9 release after last ACKed byte
        read_txn(8, 1'b0, 9);
        check(ack_addr, "R2 read address acked", 32'(ack_addr), 1);
        check(rcount == 8'h08, "R5 count byte", rcount, 8'h08);
        for (int k = 0; k < 8; k++)
            check(rbuf[k] == exp_rd(k), "R5 read data", rbuf[k], exp_rd(k));
        check(!drove, "R9 released after last counted byte", 32'(drove), 0);

        // R2 foreign address: not acked, nothing stored
        hold = 1'b1;
        i2c_start();
        send_byte(8'hA4, ack_addr);
        begin bit a; send_byte(8'h00, a); send_byte(8'h00, a); send_byte(8'hEE, a); end
        i2c_stop();
        wq(4);
        hold = 1'b0;
        check(!ack_addr, "R2 foreign address nacked", 32'(ack_addr), 0);
        check(cb(0) == 8'h00, "R2 foreign write ignored", cb(0), 8'h00);

        // R3/R4 write of four bytes
        write_txn(4);
        check(ack_addr, "R2 write address acked", 32'(ack_addr), 1);
        check(ack_hdr, "R3 command/count acked", 32'(ack_hdr), 1);
        check(ack_data, "R4 data bytes acked", 32'(ack_data), 1);
        check(cb(0) == wbuf[0] && cb(3) == wbuf[3], "R4 bytes 0..3 stored",
              {cb(0), cb(3)}, {wbuf[0], wbuf[3]});
        check(cb(4) == 8'hFF, "R4 byte 4 untouched", cb(4), 8'hFF);

        // R4 short write stops after two bytes
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'h01;
        write_txn(2);
        check(cb(0) == 8'hAA && cb(1) == 8'hBB, "R4 partial head", {cb(0), cb(1)}, 16'hAABB);
        check(cb(2) == 8'h31 + 8'(2*13), "R4 partial tail unchanged", cb(2), 8'h31 + 8'(2*13));

        // R7 vendor byte survives a write of 0x00
        write_txn(9);
        check(cb(7) == 8'h90, "R7 vendor byte read-only", cb(7), 8'h90);
        read_txn(8, 1'b1, 0);
        check(rbuf[7] == 8'h90, "R7 vendor byte read back", rbuf[7], 8'h90);

        // R8 pair 11/12: only half sent
        write_txn(12);
        check(cb(11) == 8'h00, "R8 half pair not committed", cb(11), 8'h00);
        write_txn(13);
        check(cb(11) == wbuf[11] && cb(12) == wbuf[12], "R8 full pair committed",
              {cb(11), cb(12)}, {wbuf[11], wbuf[12]});
        write_txn(14);
        check(cb(13) == 8'h00, "R8 second pair half not committed", cb(13), 8'h00);
        write_txn(15);
        check(cb(13) == wbuf[13] && cb(14) == wbuf[14], "R8 second pair committed",
              {cb(13), cb(14)}, {wbuf[13], wbuf[14]});

        // R6 length 0x18 reads beyond the implemented range
        wbuf[8] = 8'h18;
        write_txn(9);
        check(cb(8) == 8'h18, "R5 count register written", cb(8), 8'h18);
        read_txn(24, 1'b0, 0);
        check(rcount == 8'h18, "R5 count byte follows register", rcount, 8'h18);
        check(rbuf[12] == exp_rd(12) && rbuf[20] == exp_rd(20), "R5 upper bytes",
              {rbuf[12], rbuf[20]}, {exp_rd(12), exp_rd(20)});
        for (int k = 21; k < 24; k++)
            check(rbuf[k] == 8'h00, "R6 out of range reads zero", rbuf[k], 8'h00);

        // R9 master NACK ends a read early
        read_txn(3, 1'b1, 9);
        check(rbuf[2] == exp_rd(2), "R9 last byte before NACK", rbuf[2], exp_rd(2));
        check(!drove, "R9 released after NACK", 32'(drove), 0);
        read_txn(2, 1'b1, 0);
        check(rbuf[0] == exp_rd(0) && rbuf[1] == exp_rd(1), "R9 next read after NACK",
              {rbuf[0], rbuf[1]}, {exp_rd(0), exp_rd(1)});

        done = 1'b1;
        summary();
        $finish;
    end

endmodule